// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C-bus target that lets a bus master reach a small register file inside the chip. SCL and SDA come in as raw pins and pass through a synchronizer. The block finds START, repeated START and STOP, and answers one fixed 7-bit device address. It acknowledges by pulling SDA low through an open-drain enable. It never drives SDA high.

A write transfer sends the device address, then a pointer byte, then any number of data bytes. Each data byte goes to the register under the pointer, and the pointer then moves on. A read transfer uses a repeated START, or a fresh START, with the read address. Bytes come out MSB first, starting at the pointer left by an earlier write, and the pointer advances each time the master acknowledges.

The register map holds these parts:
- Eight control registers, which are read/write and also appear on a parallel output.
- Eight status bytes, which are read-only and are taken from an input vector.
- One test register, which is reachable only when the pointer is loaded with its address.

Every other address reads as FFh. Writes to it are dropped.

The byte-level controller moves through these states, in this order: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_PTR`, `ST_PTR_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA` and `ST_RACK`.
- START moves any state to `ST_ADDR`, and STOP moves any state to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` when the address matches. On a mismatch it goes to `ST_IDLE`.
- `ST_ADDR_ACK` goes to `ST_PTR` for a write and to `ST_RDATA` for a read.
- `ST_PTR` goes to `ST_PTR_ACK`, and `ST_PTR_ACK` goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- `ST_RACK` goes back to `ST_RDATA` when the master acknowledges, and to `ST_IDLE` when it does not.
Each move out of a byte or acknowledge state happens on a falling edge of SCL.

Top module: `i2c_reg_port`

## Requirements
- R1: Only the address bytes E0h (write) and E1h (read), that is 7-bit address 70h plus the R/W bit in bit 0, are acknowledged. Any other address is not acknowledged, and the block ignores the bus until the next START.
- R2: SDA is pulled low during the ninth SCL pulse of each received byte (address, pointer, data). The pull starts only while SCL is low.
- R3: In a write transfer, the first byte after the address byte loads the register pointer.
- R4: Each further write byte goes to the register under the pointer, and the pointer then increments. Byte k of the control registers appears on `ctl_out[8k+7:8k]`.
- R5: A write to a read-only address (08h–0Fh) or to an absent address changes no register. The byte is still acknowledged and the pointer still increments.
- R6: A read transfer starts at the pointer value set earlier, and START or repeated START leaves that value unchanged. Bits are sent MSB first.
- R7: When the master acknowledges a read byte, the pointer increments and the next register is sent. When the master does not acknowledge, SDA is released and the block goes idle.
- R8: Reading an absent address returns FFh.
- R9: Address 73h is a read/write test register that is reached only by an explicit pointer load. Auto-increment from 72h goes straight to 74h.
- R10: Addresses 00h–07h read back the control registers. Addresses 08h–0Fh return status byte (address − 08h), which is `sts_in[8j+7:8j]`.
- R11: After reset all registers are zero and SDA is released. A START or STOP in the middle of a byte aborts that byte without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| sts_in | input | 64 | Read-only status bytes for addresses 08h–0Fh |
| ctl_out | output | 64 | Control register contents, addresses 00h–07h |
| tst_out | output | 8 | Test register contents (address 73h) |
| wr_pulse | output | 1 | One-cycle strobe for each accepted register write |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Data of the write |

## Verification
When a write byte completes, the register write and the pointer increment happen in the same clock cycle. The write must use the old pointer, and the increment must skip the test address. To provoke this, the bench loads the pointer with 72h and writes a burst. It then judges the result at the ports: `tst_out` must not change, and a read of two bytes from 72h must return FFh twice. Reading is the same kind of case: the increment on a master acknowledge and the reload of the shift register from the next pointer fall in one cycle. A burst read across the control-to-status boundary checks it.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } fsm_state_t;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] ABSENT_VAL = 8'hFF;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_prev;
    logic              sda_prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_in;
                    sda_ff[g] <= sda_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff[g] <= 1'b1;
                    sda_ff[g] <= 1'b1;
                end else begin
                    scl_ff[g] <= scl_ff[g-1];
                    sda_ff[g] <= sda_ff[g-1];
                end
            end
        end
    end

    assign scl_lvl = scl_ff[STAGES-1];
    assign sda_lvl = sda_ff[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
    parameter int          AW        = 8,
    parameter logic [AW-1:0] TEST_ADDR = 8'h73
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr_q,
    output logic [AW-1:0] ptr_nxt
);

    logic [AW-1:0] plus_one;

    assign plus_one = ptr_q + AW'(1);
    assign ptr_nxt  = (plus_one == TEST_ADDR) ? plus_one + AW'(1) : plus_one;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (inc) begin
            ptr_q <= ptr_nxt;
        end
    end

    // R9: auto-increment never lands on the test register
    p_inc_skips_test_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (ptr_q != TEST_ADDR));

    // R3: an explicit load takes the byte as sent
    p_load_takes_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr_q == $past(load_val)));

    // R4: a load and an increment never arrive together
    p_load_inc_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && inc));

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_reg_pkg::*;
#(
    parameter int                NUM_RW    = 8,
    parameter int                NUM_RO    = 8,
    parameter logic [BYTE_W-1:0] TEST_ADDR = 8'h73,
    localparam int               CTL_W     = NUM_RW * BYTE_W,
    localparam int               STS_W     = NUM_RO * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_addr,
    input  logic [STS_W-1:0]  sts_in,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CTL_W-1:0]  ctl_out,
    output logic [BYTE_W-1:0] tst_out,
    output logic              wr_pulse
);

    logic [BYTE_W-1:0] ctl_q [NUM_RW];
    logic [BYTE_W-1:0] tst_q;
    logic              writable;

    assign writable = (wr_addr < BYTE_W'(NUM_RW)) || (wr_addr == TEST_ADDR);
    assign wr_pulse = wr_req && writable;

    for (genvar g = 0; g < NUM_RW; g++) begin : g_ctl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_q[g] <= '0;
            end else if (wr_pulse && (wr_addr == BYTE_W'(g))) begin
                ctl_q[g] <= wr_data;
            end
        end
        assign ctl_out[g*BYTE_W +: BYTE_W] = ctl_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tst_q <= '0;
        end else if (wr_pulse && (wr_addr == TEST_ADDR)) begin
            tst_q <= wr_data;
        end
    end
    assign tst_out = tst_q;

    always_comb begin
        rd_data = ABSENT_VAL;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rd_addr == BYTE_W'(i)) rd_data = ctl_q[i];
        end
        for (int j = 0; j < NUM_RO; j++) begin
            if (rd_addr == BYTE_W'(NUM_RW + j)) rd_data = sts_in[j*BYTE_W +: BYTE_W];
        end
        if (rd_addr == TEST_ADDR) rd_data = tst_q;
    end

    // R5: control registers move only on an accepted write
    p_ctl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> $stable(ctl_out));

    // R5: the test register moves only on an accepted write
    p_tst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> $stable(tst_out));

endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] ptr_q,
    input  logic [BYTE_W-1:0] ptr_nxt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] rd_addr,
    output logic              ptr_load,
    output logic              ptr_inc,
    output logic [BYTE_W-1:0] byte_val,
    output logic              wr_req,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_pull
);

    fsm_state_t        state_q, state_d;
    logic [2:0]        cnt_q;
    logic              full_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              rw_q;
    logic              mack_q;
    logic              addr_hit;

    assign addr_hit = (shreg_q[7:1] == DEV_ADDR);
    assign byte_val = shreg_q;
    assign rd_addr  = (state_q == ST_RACK) ? ptr_nxt : ptr_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (scl_fall && full_q) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_d = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (scl_fall && full_q) state_d = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (scl_fall && full_q) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && (cnt_q == 3'd7)) state_d = ST_RACK;
                ST_RACK:      if (scl_fall) state_d = mack_q ? ST_RDATA : ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            full_q   <= 1'b0;
            shreg_q  <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            sda_pull <= 1'b0;
            ptr_load <= 1'b0;
            ptr_inc  <= 1'b0;
            wr_req   <= 1'b0;
            wr_data  <= '0;
        end else begin
            ptr_load <= 1'b0;
            ptr_inc  <= 1'b0;
            wr_req   <= 1'b0;
            if (start_det || stop_det) begin
                cnt_q    <= '0;
                full_q   <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise && !full_q) begin
                            shreg_q <= {shreg_q[6:0], sda_lvl};
                            cnt_q   <= cnt_q + 3'd1;
                            if (cnt_q == 3'd7) full_q <= 1'b1;
                        end
                        if (scl_fall && full_q) begin
                            cnt_q  <= '0;
                            full_q <= 1'b0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_pull <= 1'b1;
                                    rw_q     <= shreg_q[0];
                                end
                            end else if (state_q == ST_PTR) begin
                                ptr_load <= 1'b1;
                                sda_pull <= 1'b1;
                            end else begin
                                wr_req   <= 1'b1;
                                wr_data  <= shreg_q;
                                ptr_inc  <= 1'b1;
                                sda_pull <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                shreg_q  <= rd_data;
                                sda_pull <= ~rd_data[7];
                            end else begin
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) sda_pull <= 1'b0;
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (cnt_q == 3'd7) begin
                                sda_pull <= 1'b0;
                            end else begin
                                shreg_q  <= {shreg_q[6:0], 1'b0};
                                sda_pull <= ~shreg_q[6];
                                cnt_q    <= cnt_q + 3'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mack_q <= ~sda_lvl;
                        if (scl_fall && mack_q) begin
                            ptr_inc  <= 1'b1;
                            shreg_q  <= rd_data;
                            sda_pull <= ~rd_data[7];
                            cnt_q    <= '0;
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R2: SDA is only pulled low while SCL is low
    p_pull_when_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_lvl);

    // R2: acknowledge held when the master clocks it
    p_ack_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise && (state_q == ST_ADDR_ACK || state_q == ST_PTR_ACK ||
                      state_q == ST_WDATA_ACK)) |-> sda_pull);

    // R1: a foreign address gets no acknowledge
    p_no_ack_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && scl_fall && full_q && !addr_hit && !start_det && !stop_det)
        |=> (!sda_pull && state_q == ST_IDLE));

    // R7: master NACK releases SDA and ends the transfer
    p_nack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RACK && scl_fall && !mack_q && !start_det && !stop_det)
        |=> (state_q == ST_IDLE && !sda_pull));

    // R11: idle never holds the line
    p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_pull);

endmodule

// File: rtl/i2c_reg_port.sv
module i2c_reg_port
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h70,
    parameter int         NUM_RW      = 8,
    parameter int         NUM_RO      = 8,
    parameter logic [7:0] TEST_ADDR   = 8'h73,
    parameter int         SYNC_STAGES = 2,
    localparam int        CTL_W       = NUM_RW * BYTE_W,
    localparam int        STS_W       = NUM_RO * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [STS_W-1:0]  sts_in,
    output logic [CTL_W-1:0]  ctl_out,
    output logic [BYTE_W-1:0] tst_out,
    output logic              wr_pulse,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);

    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] ptr_q, ptr_nxt, rd_addr, rd_data, byte_val;
    logic              ptr_load, ptr_inc, wr_req;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_byte_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ptr_q     (ptr_q),
        .ptr_nxt   (ptr_nxt),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .ptr_load  (ptr_load),
        .ptr_inc   (ptr_inc),
        .byte_val  (byte_val),
        .wr_req    (wr_req),
        .wr_data   (wr_data),
        .sda_pull  (sda_pull)
    );

    i2c_reg_ptr #(.AW(BYTE_W), .TEST_ADDR(TEST_ADDR)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (byte_val),
        .inc      (ptr_inc),
        .ptr_q    (ptr_q),
        .ptr_nxt  (ptr_nxt)
    );

    assign wr_addr = ptr_q;

    i2c_reg_bank #(.NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .TEST_ADDR(TEST_ADDR)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .wr_addr  (ptr_q),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .sts_in   (sts_in),
        .rd_data  (rd_data),
        .ctl_out  (ctl_out),
        .tst_out  (tst_out),
        .wr_pulse (wr_pulse)
    );

endmodule

// File: tb/test_i2c_reg_port.sv
module test_i2c_reg_port;

    localparam int Q = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_pull;
    logic [63:0] sts_in = 64'hC7C6C5C4C3C2C1C0;
    logic [63:0] ctl_out;
    logic [7:0]  tst_out;
    logic        wr_pulse;
    logic [7:0]  wr_addr;
    logic [7:0]  wr_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] exp_ctl [8];
    logic [7:0] exp_tst;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_reg_port i_i2c_reg_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .sts_in   (sts_in),
        .ctl_out  (ctl_out),
        .tst_out  (tst_out),
        .wr_pulse (wr_pulse),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    // vector: {pointer, write data, expected readback}
    localparam logic [23:0] VEC [8] = '{
        24'h00_11_11, 24'h03_A5_A5, 24'h07_3C_3C, 24'h09_77_C1,
        24'h0F_00_C7, 24'h20_12_FF, 24'h73_5A_5A, 24'hFF_99_FF
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_line; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~mack);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d, output logic ok);
        logic a0, a1, a2;
        m_start();
        send_byte(8'hE0, a0);
        send_byte(a, a1);
        send_byte(d, a2);
        m_stop();
        ok = a0 & a1 & a2;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        logic a0, a1, a2;
        m_start();
        send_byte(8'hE0, a0);
        send_byte(a, a1);
        m_start();
        send_byte(8'hE1, a2);
        recv_byte(d, 1'b0);
        chk("R7 SDA released after NACK", {63'd0, sda_pull}, 64'd0);
        m_stop();
        chk("R1 read addressing acknowledged", {61'd0, a0, a1, a2}, 64'd7);
    endtask

    task automatic chk_ctl(input string req);
        for (int k = 0; k < 8; k++) chk(req, {56'd0, ctl_out[k*8 +: 8]}, {56'd0, exp_ctl[k]});
        chk(req, {56'd0, tst_out}, {56'd0, exp_tst});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ok, ack;
        logic [7:0] d;
        for (int k = 0; k < 8; k++) exp_ctl[k] = 8'h00;
        exp_tst = 8'h00;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R11: reset state
        chk("R11 reset ctl", ctl_out, 64'd0);
        chk("R11 reset tst", {56'd0, tst_out}, 64'd0);
        chk("R11 reset SDA released", {63'd0, sda_pull}, 64'd0);

        // vector table: R3 R4 R5 R8 R9 R10
        for (int v = 0; v < 8; v++) begin
            logic [7:0] va, vd, ve;
            {va, vd, ve} = VEC[v];
            reg_write(va, vd, ok);
            chk("R2 R5 every write byte acknowledged", {63'd0, ok}, 64'd1);
            if (va < 8'h08) exp_ctl[va[2:0]] = vd;
            if (va == 8'h73) exp_tst = vd;
            chk_ctl("R4 R5 register contents after write");
            reg_read(va, d);
            chk("R8 R10 R9 readback", {56'd0, d}, {56'd0, ve});
        end

        // R6: pointer set in one transfer, read in a fresh one, MSB first
        m_start(); send_byte(8'hE0, ack); send_byte(8'h03, ack); m_stop();
        m_start(); send_byte(8'hE1, ack);
        chk("R1 read address E1 acknowledged", {63'd0, ack}, 64'd1);
        recv_byte(d, 1'b0); m_stop();
        chk("R6 read from earlier pointer", {56'd0, d}, 64'hA5);

        // R4 R5: burst write 06h..0Ah across the read-only boundary
        m_start(); send_byte(8'hE0, ack); send_byte(8'h06, ack);
        for (int b = 0; b < 5; b++) begin
            send_byte(8'h61 + 8'(b), ack);
            chk("R5 burst byte acknowledged", {63'd0, ack}, 64'd1);
        end
        m_stop();
        exp_ctl[6] = 8'h61; exp_ctl[7] = 8'h62;
        chk_ctl("R4 R5 burst write");

        // R7: burst read with master ACKs across boundary
        m_start(); send_byte(8'hE0, ack); send_byte(8'h06, ack);
        m_start(); send_byte(8'hE1, ack);
        recv_byte(d, 1'b1); chk("R7 burst read byte 0", {56'd0, d}, 64'h61);
        recv_byte(d, 1'b1); chk("R7 burst read byte 1", {56'd0, d}, 64'h62);
        recv_byte(d, 1'b1); chk("R7 R10 burst read byte 2", {56'd0, d}, 64'hC0);
        recv_byte(d, 1'b0); chk("R7 R10 burst read byte 3", {56'd0, d}, 64'hC1);
        chk("R7 release after NACK", {63'd0, sda_pull}, 64'd0);
        m_stop();

        // R9: explicit write to test register, then increment skips it
        reg_write(8'h73, 8'hA7, ok);
        exp_tst = 8'hA7;
        chk_ctl("R9 direct test write");
        m_start(); send_byte(8'hE0, ack); send_byte(8'h72, ack);
        send_byte(8'h11, ack); send_byte(8'h22, ack); m_stop();
        chk_ctl("R9 increment skips test register on write");
        m_start(); send_byte(8'hE0, ack); send_byte(8'h72, ack);
        m_start(); send_byte(8'hE1, ack);
        recv_byte(d, 1'b1); chk("R8 read 72h", {56'd0, d}, 64'hFF);
        recv_byte(d, 1'b0); chk("R9 read after 72h skips 73h", {56'd0, d}, 64'hFF);
        m_stop();
        reg_read(8'h73, d);
        chk("R9 direct test read", {56'd0, d}, 64'hA7);

        // R1: foreign addresses not acknowledged, following bytes ignored
        m_start(); send_byte(8'hE2, ack);
        chk("R1 foreign address E2 not acknowledged", {63'd0, ack}, 64'd0);
        send_byte(8'h00, ack); send_byte(8'h55, ack); m_stop();
        m_start(); send_byte(8'hE4, ack);
        chk("R1 foreign address E4 not acknowledged", {63'd0, ack}, 64'd0);
        m_stop();
        chk_ctl("R1 foreign transfer wrote nothing");

        // R11: STOP in the middle of a data byte
        m_start(); send_byte(8'hE0, ack); send_byte(8'h01, ack);
        for (int b = 0; b < 4; b++) send_bit(1'b1);
        m_stop();
        chk_ctl("R11 STOP mid-byte aborts");

        // R11: repeated START in the middle of a data byte, then a good write
        m_start(); send_byte(8'hE0, ack); send_byte(8'h02, ack);
        for (int b = 0; b < 3; b++) send_bit(1'b1);
        m_start(); send_byte(8'hE0, ack); send_byte(8'h02, ack);
        send_byte(8'h2C, ack); m_stop();
        exp_ctl[2] = 8'h2C;
        chk_ctl("R11 START mid-byte restarts cleanly");
        reg_read(8'h02, d);
        chk("R10 readback of control 02h", {56'd0, d}, 64'h2C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule